// File: doc/BRIEF.md
# Ethernet DMA Control Register File

This block is the register front end of an Ethernet DMA controller. A 32-bit memory-mapped bus writes and reads it one word at a time. The byte address is turned into a word index by dropping its two low bits. The block holds a bus mode word, an RX poll word, the RX and TX ring base pointers, the current RX and TX descriptor pointers, an operation control word, a status word and an interrupt enable word.

Some writes have side effects:
- A write to the status word clears bits instead of storing a value.
- A write to a ring base also loads the matching current-descriptor pointer.
- A write to the TX poll index sends a one-cycle kick to the transmit engine and stores nothing.

The descriptor engines report their events on single-cycle pulses, and these set status bits. The engines can also advance the current-descriptor pointers. A single level interrupt is raised while any enabled status bit is set.

Top module: `eth_dma_regs`

## Requirements
- R1: After reset every register reads zero, and `irq`, `tx_kick` and `rx_en` are low.
- R2: A write to status index 0x3C5 clears each status bit that is 1 in the written data and leaves the other bits unchanged.
- R3: `ev_tx_done` sets status bits 0 and 16. `ev_rx_done` sets bits 6 and 16. `ev_rx_nobuf` sets bits 7 and 15. An event in the same cycle as a clearing status write still sets its bits.
- R4: A write to RX base index 0x3C3 stores the data in the RX base and in the current RX descriptor (index 0x3D3). A write to TX base index 0x3C4 stores it in the TX base and in the current TX descriptor (index 0x3D2).
- R5: A write to bus mode index 0x3C0 stores the data with bit 0 forced to 0.
- R6: A write to TX poll index 0x3C1 raises `tx_kick` for exactly the one cycle after the write edge. The index stores nothing and reads zero.
- R7: `irq` is high exactly when the AND of status and interrupt enable (index 0x3C7) is non-zero. It is updated one cycle after the write or event that changes either of them.
- R8: Index 0x08 always reads 0x1012, and writes to it have no effect.
- R9: Word indices of 0x400 and above read zero, and writes to them change no register, including the register whose index matches in the low ten bits.
- R10: `rx_en` follows bit 1 of the control word at index 0x3C6.
- R11: A pulse on `tx_desc_ld` or `rx_desc_ld` loads the matching current-descriptor pointer from its `*_desc_nxt` input. In the same cycle, a bus write to that pointer or to its ring base wins over the engine load.
- R12: The RX poll, control, interrupt enable and current-descriptor indices read back what was written. Unmapped indices below 0x400 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 16 | Bus byte address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |
| tx_kick | output | 1 | One-cycle start pulse to transmit engine |
| rx_en | output | 1 | Receive enable |
| rx_base_ptr | output | 32 | RX ring base |
| tx_base_ptr | output | 32 | TX ring base |
| rx_desc_ptr | output | 32 | Current RX descriptor |
| tx_desc_ptr | output | 32 | Current TX descriptor |
| ev_tx_done | input | 1 | Transmit frame done pulse |
| ev_rx_done | input | 1 | Receive frame done pulse |
| ev_rx_nobuf | input | 1 | Receive buffer unavailable pulse |
| tx_desc_ld | input | 1 | Load current TX descriptor |
| tx_desc_nxt | input | 32 | Next TX descriptor address |
| rx_desc_ld | input | 1 | Load current RX descriptor |
| rx_desc_nxt | input | 32 | Next RX descriptor address |

## Verification
Each register, each pointer output and `rx_en` takes its new value at the clock edge that samples the write or event. `irq` follows in the same cycle, because it is formed without a register from the stored status and enable words. `tx_kick` is high only between that edge and the next one.

The bench drives inputs on falling edges and samples at the next falling edge, or one unit after changing the read address, because `rdata` is combinational. `tx_kick` is checked at two falling edges in a row, so both its high cycle and its return low are seen.

// File: rtl/eth_dma_regs.sv
module eth_dma_regs #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          tx_kick,
  output logic          rx_en,
  output logic [DW-1:0] rx_base_ptr,
  output logic [DW-1:0] tx_base_ptr,
  output logic [DW-1:0] rx_desc_ptr,
  output logic [DW-1:0] tx_desc_ptr,
  input  logic          ev_tx_done,
  input  logic          ev_rx_done,
  input  logic          ev_rx_nobuf,
  input  logic          tx_desc_ld,
  input  logic [DW-1:0] tx_desc_nxt,
  input  logic          rx_desc_ld,
  input  logic [DW-1:0] rx_desc_nxt
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] I_VER   = IW'('h008);
  localparam logic [IW-1:0] I_MODE  = IW'('h3C0);
  localparam logic [IW-1:0] I_TXPL  = IW'('h3C1);
  localparam logic [IW-1:0] I_RXPL  = IW'('h3C2);
  localparam logic [IW-1:0] I_RXB   = IW'('h3C3);
  localparam logic [IW-1:0] I_TXB   = IW'('h3C4);
  localparam logic [IW-1:0] I_STAT  = IW'('h3C5);
  localparam logic [IW-1:0] I_CTRL  = IW'('h3C6);
  localparam logic [IW-1:0] I_IEN   = IW'('h3C7);
  localparam logic [IW-1:0] I_CTXD  = IW'('h3D2);
  localparam logic [IW-1:0] I_CRXD  = IW'('h3D3);
  localparam logic [IW-1:0] I_LIMIT = IW'('h400);
  localparam logic [DW-1:0] VER_VAL = DW'('h1012);

  logic [IW-1:0] idx;
  logic          in_rng, wr;
  logic [DW-1:0] mode_q, rxpl_q, stat_q, ctrl_q, ien_q;
  logic [DW-1:0] ev_set, clr_mask;

  assign idx    = addr[AW-1:2];
  assign in_rng = idx < I_LIMIT;
  assign wr     = wr_en && in_rng;

  assign ev_set = ({DW{ev_tx_done}}  & DW'(32'h0001_0001)) |
                  ({DW{ev_rx_done}}  & DW'(32'h0001_0040)) |
                  ({DW{ev_rx_nobuf}} & DW'(32'h0000_8080));
  assign clr_mask = (wr && idx == I_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; rxpl_q <= '0; stat_q <= '0; ctrl_q <= '0; ien_q <= '0;
      rx_base_ptr <= '0; tx_base_ptr <= '0;
      rx_desc_ptr <= '0; tx_desc_ptr <= '0;
      tx_kick <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~clr_mask) | ev_set;
      tx_kick <= wr && idx == I_TXPL;
      if (rx_desc_ld) rx_desc_ptr <= rx_desc_nxt;
      if (tx_desc_ld) tx_desc_ptr <= tx_desc_nxt;
      if (wr) begin
        case (idx)
          I_MODE: mode_q <= {wdata[DW-1:1], 1'b0};
          I_RXPL: rxpl_q <= wdata;
          I_RXB:  begin rx_base_ptr <= wdata; rx_desc_ptr <= wdata; end
          I_TXB:  begin tx_base_ptr <= wdata; tx_desc_ptr <= wdata; end
          I_CTRL: ctrl_q <= wdata;
          I_IEN:  ien_q  <= wdata;
          I_CRXD: rx_desc_ptr <= wdata;
          I_CTXD: tx_desc_ptr <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq   = |(stat_q & ien_q);
  assign rx_en = ctrl_q[1];

  always_comb begin
    rdata = '0;
    if (in_rng) begin
      case (idx)
        I_VER:  rdata = VER_VAL;
        I_MODE: rdata = mode_q;
        I_RXPL: rdata = rxpl_q;
        I_RXB:  rdata = rx_base_ptr;
        I_TXB:  rdata = tx_base_ptr;
        I_STAT: rdata = stat_q;
        I_CTRL: rdata = ctrl_q;
        I_IEN:  rdata = ien_q;
        I_CRXD: rdata = rx_desc_ptr;
        I_CTXD: rdata = tx_desc_ptr;
        default: rdata = '0;
      endcase
    end
  end

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_rng && idx == I_STAT && wdata[6] && !ev_rx_done) |=> !stat_q[6]); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_nobuf |=> (stat_q[7] && stat_q[15])); // R3
  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == I_RXB) |=> (rx_desc_ptr == $past(wdata))); // R4
  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == I_TXPL) |=> tx_kick); // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && ien_q[0] && !(wr_en && idx == I_IEN)) |=> irq); // R7
  AST_OOR_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_rng) |=> $stable(mode_q)); // R9
endmodule

// File: tb/eth_dma_regs_test.sv
module eth_dma_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, tx_kick, rx_en;
  logic [31:0] rx_base_ptr, tx_base_ptr, rx_desc_ptr, tx_desc_ptr;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_rx_nobuf = 0;
  logic tx_desc_ld = 0, rx_desc_ld = 0;
  logic [31:0] tx_desc_nxt = '0, rx_desc_nxt = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  eth_dma_regs uut (.*);

  localparam int NV = 12;
  localparam logic [15:0] V_WA [NV] = '{16'h0F00, 16'h0F0C, 16'h0F10, 16'h0F18, 16'h0F1C, 16'h0020,
                                         16'h4F00, 16'h4F00, 16'h0100, 16'h0F04, 16'h0F08, 16'h0F14};
  localparam logic [31:0] V_WD [NV] = '{32'hFFFF_FFFF, 32'h1000_0040, 32'h2000_0080, 32'h2, 32'h0001_00C1, 32'hDEAD,
                                         32'h5, 32'h5, 32'h1234, 32'h1, 32'h77, 32'hFFFF_FFFF};
  localparam logic [15:0] V_RA [NV] = '{16'h0F00, 16'h0F4C, 16'h0F48, 16'h0F18, 16'h0F1C, 16'h0020,
                                         16'h0F00, 16'h4F00, 16'h0100, 16'h0F04, 16'h0F08, 16'h0F14};
  localparam logic [31:0] V_EX [NV] = '{32'hFFFF_FFFE, 32'h1000_0040, 32'h2000_0080, 32'h2, 32'h0001_00C1, 32'h1012,
                                         32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0, 32'h77, 32'h0};
  localparam string V_RQ [NV] = '{"R5", "R4", "R4", "R10", "R12", "R8", "R9", "R9", "R12", "R6", "R12", "R2"};

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string rq);
    addr = a; #1; check(rq, rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk(16'h0F00, 0, "R1"); rd_chk(16'h0F14, 0, "R1"); rd_chk(16'h0F4C, 0, "R1");
    check("R1", {29'd0, irq, tx_kick, rx_en}, 0);
    check("R1", tx_desc_ptr | rx_base_ptr, 0);

    for (int i = 0; i < NV; i++) begin
      bus_wr(V_WA[i], V_WD[i]);
      rd_chk(V_RA[i], V_EX[i], V_RQ[i]);
    end

    check("R10", {31'd0, rx_en}, 1);
    check("R4", rx_base_ptr, 32'h1000_0040);

    // R6 kick lasts one cycle
    @(negedge clk); wr_en = 1; addr = 16'h0F04;
    @(negedge clk); wr_en = 0; check("R6", {31'd0, tx_kick}, 1);
    @(negedge clk); check("R6", {31'd0, tx_kick}, 0);

    // R3 / R7 event sets status, irq rises
    ev_tx_done = 1; @(negedge clk); ev_tx_done = 0;
    rd_chk(16'h0F14, 32'h0001_0001, "R3");
    check("R7", {31'd0, irq}, 1);
    bus_wr(16'h0F14, 32'h0001_0001);
    rd_chk(16'h0F14, 0, "R2");
    check("R7", {31'd0, irq}, 0);

    // R3 event wins over a clearing write in the same cycle
    @(negedge clk); wr_en = 1; addr = 16'h0F14; wdata = 32'hFFFF_FFFF; ev_rx_nobuf = 1;
    @(negedge clk); wr_en = 0; ev_rx_nobuf = 0;
    rd_chk(16'h0F14, 32'h0000_8080, "R3");
    check("R7", {31'd0, irq}, 1);
    bus_wr(16'h0F14, 32'h0000_8000);
    rd_chk(16'h0F14, 32'h0000_0080, "R2");
    bus_wr(16'h0F1C, 32'h0);
    check("R7", {31'd0, irq}, 0);
    ev_rx_done = 1; @(negedge clk); ev_rx_done = 0;
    rd_chk(16'h0F14, 32'h0001_00C0, "R3");

    // R11 engine loads and bus priority
    tx_desc_nxt = 32'h2000_00A0; tx_desc_ld = 1; @(negedge clk); tx_desc_ld = 0;
    check("R11", tx_desc_ptr, 32'h2000_00A0);
    @(negedge clk); wr_en = 1; addr = 16'h0F10; wdata = 32'h3000_0000;
    tx_desc_ld = 1; tx_desc_nxt = 32'h5;
    @(negedge clk); wr_en = 0; tx_desc_ld = 0;
    check("R11", tx_desc_ptr, 32'h3000_0000);
    rx_desc_nxt = 32'h1000_0060; rx_desc_ld = 1; @(negedge clk); rx_desc_ld = 0;
    rd_chk(16'h0F4C, 32'h1000_0060, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule